// File: doc/BRIEF.md
# Machine-Mode CSR File and Trap Controller

This block holds the machine-level control and status registers of a 32-bit in-order core and decides, cycle by cycle, whether the pipeline must be redirected. The execute stage presents at most one CSR access per cycle: an address, an operation code and an operand. It receives the old register value combinationally on `csr_rdata` and the update lands on the next clock edge. Immediate forms of the set, clear and write instructions are handled by decode, which places the zero-extended 5-bit immediate on `csr_wdata`.

Environment-call and breakpoint strobes arrive with the PC of the faulting instruction. Three interrupt lines (software, timer, external) are sampled live. An MRET strobe returns from a handler. In the same cycle as a trap or return, the block raises `redirect_valid` and supplies `redirect_pc`. It updates the return address, the cause and the interrupt-enable stack on the following edge. A free-running 64-bit cycle counter is visible on two output ports and through two read-only CSRs.

Top module: `mcsr_trap_unit`

## Requirements
- R1: After reset, mstatus reads 0x1880, misa reads 0x40000100, mhartid reads 0, and mie, mtvec, mscratch, mepc, mcause and mtval read 0.
- R2: `csr_op` 1 writes the operand, 2 sets the operand's bits, 3 clears them, and 0 does nothing. `csr_rdata` always shows the value before the update, and the update is visible from the next cycle.
- R3: The implemented addresses are mstatus 0x300, misa 0x301, mie 0x304, mtvec 0x305, mscratch 0x340, mepc 0x341, mcause 0x342, mtval 0x343, mip 0x344, cycle 0xC00, cycleh 0xC80 and mhartid 0xF14. Any other address with `csr_en` high raises `csr_illegal` and reads 0.
- R4: Writes to misa, mhartid, mip, cycle and cycleh have no effect.
- R5: In mstatus only MIE (bit 3) and MPIE (bit 7) are writable, and MPP (bits 12:11) always reads 3. In mie only bits 3, 7 and 11 are writable. mtvec bit 1 and mepc bits 1:0 always read 0.
- R6: The 64-bit cycle counter increments every cycle and carries from the low word into the high word. Its low and high halves appear on `cycle_lo`/`cycle_hi` and read at 0xC00/0xC80.
- R7: An ECALL or EBREAK strobe raises `trap_taken` and `redirect_valid` in the same cycle. It then writes the PC to mepc, writes 11 (ECALL) or 3 (EBREAK) to mcause, and clears mtval.
- R8: An interrupt is taken only when mstatus.MIE and its mie bit are both 1. mip bits 3 (software), 7 (timer) and 11 (external) follow the request lines.
- R9: The trap target is mtvec with its two low bits cleared. When mtvec bit 0 is 1, an interrupt adds 4 times its code (software 3, timer 7, external 11) to that base and writes the code to mcause with bit 31 set. Exceptions always go to the base.
- R10: Among pending enabled interrupts, external wins over software, which wins over timer. An enabled interrupt wins over an exception strobe in the same cycle.
- R11: A trap copies MIE into MPIE and clears MIE.
- R12: MRET redirects to mepc, copies MPIE into MIE and sets MPIE. A trap in the same cycle overrides the MRET.
- R13: A CSR write presented in a cycle where a trap is taken has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access valid |
| csr_op | input | 2 | 0 none, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Operand (register or zero-extended immediate) |
| csr_rdata | output | 32 | Value before the update |
| csr_illegal | output | 1 | Access to an unimplemented address |
| ecall | input | 1 | Environment-call strobe |
| ebreak | input | 1 | Breakpoint strobe |
| pc_in | input | 32 | PC of the instruction in execute |
| mret | input | 1 | Return-from-trap strobe |
| irq_sw | input | 1 | Software interrupt request |
| irq_tmr | input | 1 | Timer interrupt request |
| irq_ext | input | 1 | External interrupt request |
| trap_taken | output | 1 | A trap is taken this cycle |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | 32 | Trap target or return address |
| cycle_lo | output | 32 | Cycle counter bits 31:0 |
| cycle_hi | output | 32 | Cycle counter bits 63:32 |

## Verification
Three kinds of events can land in one cycle: an interrupt becoming takeable, an exception or MRET strobe, and a CSR write from the same instruction. The bench raises all three interrupt lines together with ECALL and a write to mscratch. It then checks that the redirect goes to the external-interrupt vector and that mcause shows the external code. It also reads mscratch back to confirm the write was dropped. A further cycle drives ECALL and MRET together and expects the exception base rather than the saved return address.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_WRITE = 2'd1, OP_SET = 2'd2, OP_CLEAR = 2'd3} csr_op_e;

  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MISA     = 12'h301;
  localparam logic [11:0] A_MIE      = 12'h304;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_MTVAL    = 12'h343;
  localparam logic [11:0] A_MIP      = 12'h344;
  localparam logic [11:0] A_CYCLE    = 12'hC00;
  localparam logic [11:0] A_CYCLEH   = 12'hC80;
  localparam logic [11:0] A_MHARTID  = 12'hF14;

  localparam logic [31:0] MISA_VAL = 32'h4000_0100;

  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] C_IRQ_SW  = 5'd3;
  localparam logic [CODE_W-1:0] C_IRQ_TMR = 5'd7;
  localparam logic [CODE_W-1:0] C_IRQ_EXT = 5'd11;
  localparam logic [CODE_W-1:0] C_ECALL   = 5'd11;
  localparam logic [CODE_W-1:0] C_BREAK   = 5'd3;

  // read-modify-write of one CSR
  function automatic logic [31:0] csr_apply(input logic [31:0] old, input csr_op_e op,
                                            input logic [31:0] opnd);
    case (op)
      OP_WRITE: csr_apply = opnd;
      OP_SET:   csr_apply = old | opnd;
      OP_CLEAR: csr_apply = old & ~opnd;
      default:  csr_apply = old;
    endcase
  endfunction

  // trap destination from mtvec
  function automatic logic [31:0] trap_dest(input logic [31:0] tvec, input logic is_irq,
                                            input logic [CODE_W-1:0] code);
    logic [31:0] base;
    base = {tvec[31:2], 2'b00};
    if (is_irq && tvec[0]) trap_dest = base + {25'd0, code, 2'b00};
    else                   trap_dest = base;
  endfunction
endpackage

// File: rtl/mcsr_cycle_ctr.sv
module mcsr_cycle_ctr #(
  parameter int          W    = 64,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= INIT;
    else        cnt_q <= cnt_q + W'(1);
  end

  assign count = cnt_q;

  // R6
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/mcsr_irq_arb.sv
module mcsr_irq_arb
  import mcsr_pkg::*;
(
  input  logic              gie,
  input  logic [2:0]        req,     // {ext, tmr, sw}
  input  logic [2:0]        en,
  output logic              any,
  output logic [CODE_W-1:0] code
);
  logic [2:0] live;
  logic [2:0] grant;

  assign live = gie ? (req & en) : 3'b000;

  always_comb begin
    grant = 3'b000;
    code  = '0;
    if (live[2]) begin
      grant = 3'b100; code = C_IRQ_EXT;
    end else if (live[0]) begin
      grant = 3'b001; code = C_IRQ_SW;
    end else if (live[1]) begin
      grant = 3'b010; code = C_IRQ_TMR;
    end
  end

  assign any = |grant;

  // R10
  grant_onehot_chk: assert final ($onehot0(grant));
  // R8
  grant_enabled_chk: assert final ((grant & ~(req & en)) == 3'b000 && (gie || grant == 3'b000));
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
  import mcsr_pkg::*;
#(
  parameter logic [31:0] HART_ID    = 32'd0,
  parameter logic [63:0] CYCLE_INIT = 64'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_en,
  input  logic [1:0]  csr_op,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        csr_illegal,
  input  logic        ecall,
  input  logic        ebreak,
  input  logic [31:0] pc_in,
  input  logic        mret,
  input  logic        irq_sw,
  input  logic        irq_tmr,
  input  logic        irq_ext,
  output logic        trap_taken,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic [31:0] cycle_lo,
  output logic [31:0] cycle_hi
);
  localparam int CNT_W = 64;

  logic        st_mie_q, st_mpie_q;
  logic [2:0]  ie_q;            // {ext, tmr, sw}
  logic [31:0] mtvec_q, mscratch_q, mepc_q, mcause_q, mtval_q;
  logic [CNT_W-1:0] cyc;

  csr_op_e     op_e;
  logic        hit, wr_en, writable;
  logic [31:0] rd_raw, wval;
  logic        irq_any, exc_take;
  logic [CODE_W-1:0] irq_code;
  logic [31:0] cause_val, tgt;

  mcsr_cycle_ctr #(.W(CNT_W), .INIT(CYCLE_INIT)) u_ctr (
    .clk(clk), .rst_n(rst_n), .count(cyc));

  mcsr_irq_arb u_arb (
    .gie(st_mie_q), .req({irq_ext, irq_tmr, irq_sw}), .en(ie_q),
    .any(irq_any), .code(irq_code));

  assign op_e = csr_op_e'(csr_op);

  // read mux and decode
  always_comb begin
    hit      = 1'b1;
    writable = 1'b1;
    rd_raw   = '0;
    case (csr_addr)
      A_MSTATUS:  rd_raw = {19'd0, 2'b11, 3'd0, st_mpie_q, 3'd0, st_mie_q, 3'd0};
      A_MISA:     begin rd_raw = MISA_VAL; writable = 1'b0; end
      A_MIE:      rd_raw = {20'd0, ie_q[2], 3'd0, ie_q[1], 3'd0, ie_q[0], 3'd0};
      A_MTVEC:    rd_raw = mtvec_q;
      A_MSCRATCH: rd_raw = mscratch_q;
      A_MEPC:     rd_raw = mepc_q;
      A_MCAUSE:   rd_raw = mcause_q;
      A_MTVAL:    rd_raw = mtval_q;
      A_MIP:      begin rd_raw = {20'd0, irq_ext, 3'd0, irq_tmr, 3'd0, irq_sw, 3'd0}; writable = 1'b0; end
      A_CYCLE:    begin rd_raw = cyc[31:0];  writable = 1'b0; end
      A_CYCLEH:   begin rd_raw = cyc[63:32]; writable = 1'b0; end
      A_MHARTID:  begin rd_raw = HART_ID; writable = 1'b0; end
      default:    begin hit = 1'b0; writable = 1'b0; end
    endcase
  end

  assign csr_rdata   = csr_en ? rd_raw : '0;
  assign csr_illegal = csr_en & ~hit;
  assign wval        = csr_apply(rd_raw, op_e, csr_wdata);

  // trap decision
  assign exc_take   = ecall | ebreak;
  assign trap_taken = irq_any | exc_take;
  assign cause_val  = irq_any ? {1'b1, 26'd0, irq_code} :
                      {27'd0, (ecall ? C_ECALL : C_BREAK)};
  assign tgt        = trap_dest(mtvec_q, irq_any, irq_code);
  assign wr_en      = csr_en && (op_e != OP_NONE) && writable && !trap_taken;

  assign redirect_valid = trap_taken | mret;
  assign redirect_pc    = trap_taken ? tgt : mepc_q;
  assign cycle_lo       = cyc[31:0];
  assign cycle_hi       = cyc[63:32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_mie_q   <= 1'b0;
      st_mpie_q  <= 1'b1;
      ie_q       <= '0;
      mtvec_q    <= '0;
      mscratch_q <= '0;
      mepc_q     <= '0;
      mcause_q   <= '0;
      mtval_q    <= '0;
    end else if (trap_taken) begin
      st_mpie_q <= st_mie_q;
      st_mie_q  <= 1'b0;
      mepc_q    <= pc_in & ~32'h3;
      mcause_q  <= cause_val;
      mtval_q   <= '0;
    end else begin
      if (wr_en) begin
        case (csr_addr)
          A_MSTATUS:  begin st_mie_q <= wval[3]; st_mpie_q <= wval[7]; end
          A_MIE:      ie_q <= {wval[11], wval[7], wval[3]};
          A_MTVEC:    mtvec_q <= {wval[31:2], 1'b0, wval[0]};
          A_MSCRATCH: mscratch_q <= wval;
          A_MEPC:     mepc_q <= {wval[31:2], 2'b00};
          A_MCAUSE:   mcause_q <= wval;
          A_MTVAL:    mtval_q <= wval;
          default:    ;
        endcase
      end
      if (mret) begin
        st_mie_q  <= st_mpie_q;
        st_mpie_q <= 1'b1;
      end
    end
  end

  // R11
  trap_clears_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> !st_mie_q && st_mpie_q == $past(st_mie_q));
  // R7
  trap_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> mepc_q == ($past(pc_in) & ~32'h3));
  // R12
  mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !trap_taken) |=> st_mpie_q && st_mie_q == $past(st_mpie_q));
  // R13
  trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> $stable(mscratch_q) && $stable(mtvec_q) && $stable(ie_q));
endmodule

// File: tb/mcsr_trap_unit_test.sv
module mcsr_trap_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        csr_en = 0, ecall = 0, ebreak = 0, mret = 0;
  logic        irq_sw = 0, irq_tmr = 0, irq_ext = 0;
  logic [1:0]  csr_op = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, pc_in = 0;
  logic [31:0] csr_rdata, redirect_pc, cycle_lo, cycle_hi;
  logic        csr_illegal, trap_taken, redirect_valid;
  logic [31:0] w_lo, w_hi;

  mcsr_trap_unit uut (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .ecall(ecall), .ebreak(ebreak), .pc_in(pc_in), .mret(mret),
    .irq_sw(irq_sw), .irq_tmr(irq_tmr), .irq_ext(irq_ext),
    .trap_taken(trap_taken), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .cycle_lo(cycle_lo), .cycle_hi(cycle_hi));

  mcsr_trap_unit #(.CYCLE_INIT(64'h0000_0000_FFFF_FFF0)) uut_wrap (
    .clk(clk), .rst_n(rst_n), .csr_en(1'b0), .csr_op(2'd0), .csr_addr(12'd0),
    .csr_wdata(32'd0), .csr_rdata(), .csr_illegal(),
    .ecall(1'b0), .ebreak(1'b0), .pc_in(32'd0), .mret(1'b0),
    .irq_sw(1'b0), .irq_tmr(1'b0), .irq_ext(1'b0),
    .trap_taken(), .redirect_valid(), .redirect_pc(),
    .cycle_lo(w_lo), .cycle_hi(w_hi));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // {op, addr, operand, expected old value, expected illegal}
  localparam int NV = 25;
  localparam logic [78:0] VECS [NV] = '{
    {2'd1, 12'h340, 32'hA5A5_0F0F, 32'h0000_0000, 1'b0},
    {2'd2, 12'h340, 32'h0000_00F0, 32'hA5A5_0F0F, 1'b0},
    {2'd3, 12'h340, 32'hA500_0000, 32'hA5A5_0FFF, 1'b0},
    {2'd2, 12'h340, 32'h0000_0000, 32'h00A5_0FFF, 1'b0},
    {2'd1, 12'h301, 32'h0000_0000, 32'h4000_0100, 1'b0},
    {2'd2, 12'h301, 32'h0000_0000, 32'h4000_0100, 1'b0},
    {2'd1, 12'hF14, 32'h0000_FFFF, 32'h0000_0000, 1'b0},
    {2'd2, 12'hF14, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {2'd1, 12'h341, 32'h0000_1237, 32'h0000_0000, 1'b0},
    {2'd2, 12'h341, 32'h0000_0000, 32'h0000_1234, 1'b0},
    {2'd1, 12'h305, 32'h8000_0103, 32'h0000_0000, 1'b0},
    {2'd2, 12'h305, 32'h0000_0000, 32'h8000_0101, 1'b0},
    {2'd1, 12'h300, 32'hFFFF_FFFF, 32'h0000_1880, 1'b0},
    {2'd3, 12'h300, 32'h0000_0008, 32'h0000_1888, 1'b0},
    {2'd2, 12'h300, 32'h0000_0000, 32'h0000_1880, 1'b0},
    {2'd1, 12'h304, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    {2'd2, 12'h304, 32'h0000_0000, 32'h0000_0888, 1'b0},
    {2'd1, 12'h304, 32'h0000_0000, 32'h0000_0888, 1'b0},
    {2'd1, 12'h344, 32'h0000_FFFF, 32'h0000_0000, 1'b0},
    {2'd2, 12'h344, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {2'd1, 12'h342, 32'h8000_000B, 32'h0000_0000, 1'b0},
    {2'd2, 12'h342, 32'h0000_0000, 32'h8000_000B, 1'b0},
    {2'd1, 12'h343, 32'h0000_DEAD, 32'h0000_0000, 1'b0},
    {2'd2, 12'h343, 32'h0000_0000, 32'h0000_DEAD, 1'b0},
    {2'd2, 12'h7C0, 32'h0000_0000, 32'h0000_0000, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [31:0] v);
    csr_en = 1; csr_op = 2'd2; csr_addr = a; csr_wdata = 0;
    @(negedge clk); v = csr_rdata;
    @(posedge clk); #1; csr_en = 0; csr_op = 0;
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    csr_en = 1; csr_op = 2'd1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1; csr_en = 0; csr_op = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] v, c0;
    // R1 reset state
    @(negedge clk);
    chk("R1 cycle_lo in reset", cycle_lo, 32'd0);
    chk("R1 trap_taken in reset", {31'd0, trap_taken}, 32'd0);
    @(posedge clk); #1; rst_n = 1;
    csr_rd(12'h300, v); chk("R1 mstatus reset", v, 32'h0000_1880);

    // R2 R3 R4 R5 table
    for (int i = 0; i < NV; i++) begin
      csr_en = 1; csr_op = VECS[i][78:77]; csr_addr = VECS[i][76:65]; csr_wdata = VECS[i][64:33];
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5 vec %0d rdata", i), csr_rdata, VECS[i][32:1]);
      chk($sformatf("R3 vec %0d illegal", i), {31'd0, csr_illegal}, {31'd0, VECS[i][0]});
      @(posedge clk); #1;
    end
    csr_en = 0; csr_op = 0;

    // R6 counter
    @(negedge clk); c0 = cycle_lo;
    @(negedge clk); chk("R6 step", cycle_lo, c0 + 1);
    @(posedge clk); #1;
    csr_en = 1; csr_op = 2'd2; csr_addr = 12'hC00; csr_wdata = 0;
    @(negedge clk); chk("R6 cycle read", csr_rdata, cycle_lo);
    @(posedge clk); #1; csr_addr = 12'hC80;
    @(negedge clk); chk("R6 cycleh read", csr_rdata, cycle_hi);
    @(posedge clk); #1; csr_en = 0;
    csr_wr(12'hC00, 32'd0);
    @(negedge clk); chk("R4 cycle write ignored", {31'd0, (cycle_lo > 32'd20)}, 32'd1);
    chk("R6 carry into high", w_hi, 32'd1);
    @(posedge clk); #1;

    // R7 ECALL, direct mode
    csr_wr(12'h305, 32'h0000_0100);
    csr_wr(12'h300, 32'h0000_0008);
    ecall = 1; pc_in = 32'h2000;
    @(negedge clk);
    chk("R7 ecall trap_taken", {30'd0, trap_taken, redirect_valid}, 32'd3);
    chk("R7 ecall target", redirect_pc, 32'h0000_0100);
    @(posedge clk); #1; ecall = 0;
    csr_rd(12'h341, v); chk("R7 mepc", v, 32'h2000);
    csr_rd(12'h342, v); chk("R7 mcause ecall", v, 32'd11);
    csr_rd(12'h343, v); chk("R7 mtval cleared", v, 32'd0);
    csr_rd(12'h300, v); chk("R11 MPIE<=1 MIE<=0", v, 32'h0000_1880);

    // R9 EBREAK in vectored mode goes to base
    csr_wr(12'h305, 32'h8000_0101);
    ebreak = 1; pc_in = 32'h3004;
    @(negedge clk); chk("R9 ebreak base", redirect_pc, 32'h8000_0100);
    @(posedge clk); #1; ebreak = 0;
    csr_rd(12'h342, v); chk("R7 mcause break", v, 32'd3);

    // R8 gating
    irq_tmr = 1; pc_in = 32'h4000;
    @(negedge clk); chk("R8 no trap with mie clear", {31'd0, trap_taken}, 32'd0);
    @(posedge clk); #1;
    csr_rd(12'h344, v); chk("R8 mip timer", v, 32'h0000_0080);
    csr_wr(12'h304, 32'h0000_0080);
    @(negedge clk); chk("R8 no trap with MIE clear", {31'd0, trap_taken}, 32'd0);
    @(posedge clk); #1;
    csr_wr(12'h300, 32'h0000_0008);
    @(negedge clk);
    chk("R8 timer trap", {31'd0, trap_taken}, 32'd1);
    chk("R9 timer vector", redirect_pc, 32'h8000_011C);
    @(posedge clk); #1;
    @(negedge clk); chk("R11 no retrap after MIE cleared", {31'd0, trap_taken}, 32'd0);
    @(posedge clk); #1; irq_tmr = 0;
    csr_rd(12'h342, v); chk("R9 mcause timer", v, 32'h8000_0007);

    // R12 MRET
    mret = 1;
    @(negedge clk);
    chk("R12 mret redirect", redirect_pc, 32'h4000);
    chk("R12 mret flags", {30'd0, trap_taken, redirect_valid}, 32'd1);
    @(posedge clk); #1; mret = 0;
    csr_rd(12'h300, v); chk("R12 mstatus after mret", v, 32'h0000_1888);

    // R10 R13 everything in one cycle
    csr_wr(12'h304, 32'h0000_0888);
    irq_sw = 1; irq_tmr = 1; irq_ext = 1; ecall = 1; pc_in = 32'h5000;
    csr_en = 1; csr_op = 2'd1; csr_addr = 12'h340; csr_wdata = 32'h1111;
    @(negedge clk);
    chk("R10 external wins", redirect_pc, 32'h8000_012C);
    @(posedge clk); #1;
    irq_sw = 0; irq_tmr = 0; irq_ext = 0; ecall = 0; csr_en = 0; csr_op = 0;
    csr_rd(12'h342, v); chk("R10 mcause external", v, 32'h8000_000B);
    csr_rd(12'h341, v); chk("R10 mepc", v, 32'h5000);
    csr_rd(12'h340, v); chk("R13 mscratch untouched", v, 32'h00A5_0FFF);
    mret = 1; tick(); mret = 0;
    irq_sw = 1; irq_tmr = 1;
    @(negedge clk); chk("R10 software beats timer", redirect_pc, 32'h8000_010C);
    @(posedge clk); #1; irq_sw = 0; irq_tmr = 0;
    csr_rd(12'h342, v); chk("R9 mcause software", v, 32'h8000_0003);
    mret = 1; tick(); mret = 0;

    // R12 trap beats mret
    ecall = 1; mret = 1; pc_in = 32'h6000;
    @(negedge clk); chk("R12 trap over mret", redirect_pc, 32'h8000_0100);
    @(posedge clk); #1; ecall = 0; mret = 0;
    csr_rd(12'h341, v); chk("R12 mepc from trap", v, 32'h6000);
    csr_rd(12'h300, v); chk("R11 MIE cleared", v, 32'h0000_1880);

    summary();
  end
endmodule